// File: doc/BRIEF.md
# Multi-port hardware mutex bank

This block holds a set of one-bit mutual-exclusion flags that several processors can reach over a simple register port. Each processor gets its own request port with valid, write and byte address inputs, plus a registered read-data output. Reading a flag's word tries to take that flag. The returned value shows whether the attempt worked. Writing the word gives the flag back. Software that fails simply reads again. The block never queues or stalls a requester.

A separate read-only word reports all flags at once. Requests from every port are resolved in the same clock cycle. If two ports race for the same free flag, a fixed ranking picks the winner. If one port frees a flag while another port grabs it, the release is applied first and then the grab.

Top module: `hwlock_bank`

## Requirements
- R1: With the default of 32 locks, lock n (0 to 31) lives at byte address 4*n, and only addresses with the two low bits at zero select a lock.
- R2: A read of a free lock marks it held, and one clock later returns the value with only bit n set (1 << n).
- R3: A read of a held lock returns zero and leaves every lock's state as it was.
- R4: A write to lock n's address releases lock n, and the write response reads zero. Releasing a lock that is already free changes nothing.
- R5: A read of the status word at byte address 0x80 returns bit n set for each held lock n. It reports the state from before that cycle's claims and releases.
- R6: When several ports read the same free lock in one cycle, the lowest-numbered port alone gets the one-hot value, and the others get zero.
- R7: When one port releases a lock in the same cycle that another port reads it, the read succeeds and the lock stays held.
- R8: An address that is misaligned or lies above the status word returns zero and changes no lock. A write to the status word is ignored.
- R9: A synchronous active-low reset frees every lock and sets all read-data outputs to zero.
- R10: A request whose valid input is low has no effect, even when its write and address inputs select a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NUM_PORTS | Per-port request strobe |
| req_write | input | NUM_PORTS | Per-port direction, 1 = release write, 0 = read |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p in slice p |
| rsp_rdata | output | NUM_PORTS*DATA_W | Per-port read data, valid one clock after the request |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, two ports read one free lock together. In the other, one port releases a lock while the other port claims it. Both cases need the two ports driven with exact alignment on one clock edge, and each needs a known lock state set up beforehand. The stimulus table puts both ports' requests into a single vector, so every collision lands in one cycle. Status-word reads placed between these vectors show that the loser took nothing and that the re-claimed lock is still held.

// File: rtl/hwlock_pkg.sv
// Shared types for the hardware mutex bank.
// Assumes: one decoded operation per port per cycle.
package hwlock_pkg;

    // Decoded request kind for one port in one cycle.
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_CLAIM   = 2'd1,
        OP_RELEASE = 2'd2,
        OP_STATUS  = 2'd3
    } lock_op_e;

endpackage

// File: rtl/hwlock_decode.sv
// Address decoder for one request port.
// Maps a byte address to a claim, release or status operation and a
// one-hot lock selector. Misaligned addresses, addresses past the lock
// range other than the status word, and status writes decode to OP_NONE.
// Assumes: ADDR_W is wide enough to hold STATUS_OFFSET.
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS     = 32,
    parameter int ADDR_W        = 8,
    parameter int STATUS_OFFSET = 4 * NUM_LOCKS
) (
    input  logic                 valid,
    input  logic                 write,
    input  logic [ADDR_W-1:0]    addr,
    output lock_op_e             op,
    output logic [NUM_LOCKS-1:0] lock_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             in_range;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign in_range = (int'(word_idx) < NUM_LOCKS);

    // Classify the request and form the lock selector.
    always_comb begin
        op       = OP_NONE;
        lock_sel = '0;
        if (valid) begin
            if (aligned && in_range) begin
                op = write ? OP_RELEASE : OP_CLAIM;
                for (int l = 0; l < NUM_LOCKS; l++) begin
                    lock_sel[l] = (word_idx == IDX_W'(l));
                end
            end else if (addr == ADDR_W'(STATUS_OFFSET) && !write) begin
                op = OP_STATUS;
            end
        end
    end

endmodule

// File: rtl/hwlock_arbiter.sv
// Per-lock same-cycle resolution across all ports.
// A lock is available when it is free or is being released this cycle.
// Among claimers of an available lock, the lowest port index wins.
// Assumes: claim and release requests are already decoded, one-hot per port.
module hwlock_arbiter #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_LOCKS-1:0]                 held_q,
    input  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  claim_req,
    input  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  release_req,
    output logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  grant,
    output logic [NUM_LOCKS-1:0]                 set_mask,
    output logic [NUM_LOCKS-1:0]                 clr_mask
);

    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
        logic [NUM_PORTS-1:0] win;
        logic                 rel_any;

        // Fixed-priority pick of one claimer, release applied first.
        always_comb begin
            logic taken;
            rel_any = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                rel_any = rel_any | release_req[p][l];
            end
            taken = held_q[l] && !rel_any;
            for (int p = 0; p < NUM_PORTS; p++) begin
                win[p] = claim_req[p][l] && !taken;
                taken  = taken | claim_req[p][l];
            end
        end

        assign set_mask[l] = |win;
        assign clr_mask[l] = rel_any;

        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign grant[p][l] = win[p];
        end

        // R6
        win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(win));
    end

endmodule

// File: rtl/hwlock_state.sv
// Lock state register.
// Each cycle, releases clear their bits and grants then set theirs.
// Assumes: set_mask only carries locks that are free or released this cycle.
module hwlock_state #(
    parameter int NUM_LOCKS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LOCKS-1:0] set_mask,
    input  logic [NUM_LOCKS-1:0] clr_mask,
    output logic [NUM_LOCKS-1:0] held_q
);

    // Hold lock flags; reset frees all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= (held_q & ~clr_mask) | set_mask;
        end
    end

    // R2
    rise_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((held_q & ~$past(held_q) & ~$past(set_mask)) == '0));

    // R4
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((held_q & $past(clr_mask) & ~$past(set_mask)) == '0));

    // R3
    no_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask & held_q & ~clr_mask) == '0));

endmodule

// File: rtl/hwlock_bank.sv
// Multi-port hardware mutex bank, top level.
// Decodes each port, resolves claims and releases per lock, updates the
// lock state and registers a one-cycle read response per port.
// Assumes: DATA_W >= NUM_LOCKS; one request per port per cycle.
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_PORTS     = 2,
    parameter int NUM_LOCKS     = 32,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int STATUS_OFFSET = 4 * NUM_LOCKS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS-1:0]        req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    output logic [NUM_PORTS*DATA_W-1:0] rsp_rdata
);

    lock_op_e                             op_w  [NUM_PORTS];
    logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  sel_w;
    logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  claim_req;
    logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  release_req;
    logic [NUM_PORTS-1:0][NUM_LOCKS-1:0]  grant;
    logic [NUM_LOCKS-1:0]                 set_mask;
    logic [NUM_LOCKS-1:0]                 clr_mask;
    logic [NUM_LOCKS-1:0]                 held_q;
    logic [NUM_PORTS-1:0][DATA_W-1:0]     rsp_d;
    logic [NUM_PORTS-1:0][DATA_W-1:0]     rsp_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hwlock_decode #(
            .NUM_LOCKS    (NUM_LOCKS),
            .ADDR_W       (ADDR_W),
            .STATUS_OFFSET(STATUS_OFFSET)
        ) u_dec (
            .valid   (req_valid[p]),
            .write   (req_write[p]),
            .addr    (req_addr[p*ADDR_W +: ADDR_W]),
            .op      (op_w[p]),
            .lock_sel(sel_w[p])
        );

        assign claim_req[p]   = (op_w[p] == OP_CLAIM)   ? sel_w[p] : '0;
        assign release_req[p] = (op_w[p] == OP_RELEASE) ? sel_w[p] : '0;

        // Form this port's response from its grant or the status snapshot.
        always_comb begin
            case (op_w[p])
                OP_CLAIM:  rsp_d[p] = DATA_W'(grant[p]);
                OP_STATUS: rsp_d[p] = DATA_W'(held_q);
                default:   rsp_d[p] = '0;
            endcase
        end

        // R8
        miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_w[p] == OP_NONE || op_w[p] == OP_RELEASE) |=> (rsp_q[p] == '0));

        // R2
        claim_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_w[p] == OP_CLAIM) |=>
                (rsp_q[p] == '0 || rsp_q[p] == DATA_W'($past(sel_w[p]))));
    end

    hwlock_arbiter #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_LOCKS(NUM_LOCKS)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .held_q     (held_q),
        .claim_req  (claim_req),
        .release_req(release_req),
        .grant      (grant),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask)
    );

    hwlock_state #(
        .NUM_LOCKS(NUM_LOCKS)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .held_q  (held_q)
    );

    // Register the per-port responses; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_rdata = rsp_q;

endmodule

// File: tb/sim_hwlock_bank.sv
module sim_hwlock_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req_valid = '0;
    logic [1:0]  req_write = '0;
    logic [15:0] req_addr = '0;
    logic [63:0] rsp_rdata;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hwlock_bank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        v0;
        logic        w0;
        logic [7:0]  a0;
        logic        v1;
        logic        w1;
        logic [7:0]  a1;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 32'h0000_0001, 32'h0},           // R2 claim lock0
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 32'h0, 32'h0},                   // R3 lock0 held
        '{1'b1, 1'b0, 8'h80, 1'b1, 1'b0, 8'h14, 32'h0000_0001, 32'h0000_0020},   // R5 status, R1 lock5
        '{1'b1, 1'b0, 8'h0C, 1'b1, 1'b0, 8'h0C, 32'h0000_0008, 32'h0},           // R6 tie on lock3
        '{1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 8'h00, 32'h0000_0029, 32'h0},           // R6 loser took nothing
        '{1'b1, 1'b0, 8'h0C, 1'b1, 1'b1, 8'h0C, 32'h0000_0008, 32'h0},           // R7 release+claim lock3
        '{1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 32'h0, 32'h0000_0001},           // R7 release+claim lock0
        '{1'b1, 1'b1, 8'h80, 1'b1, 1'b0, 8'h84, 32'h0, 32'h0},                   // R8 status write, out of range
        '{1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 8'h00, 32'h0000_0029, 32'h0},           // R8 nothing changed
        '{1'b1, 1'b1, 8'h7C, 1'b1, 1'b0, 8'h7C, 32'h0, 32'h8000_0000},           // R4 free release, R1 lock31
        '{1'b1, 1'b0, 8'h02, 1'b1, 1'b0, 8'h7C, 32'h0, 32'h0},                   // R8 misaligned, R3
        '{1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 8'h00, 32'h8000_0029, 32'h0},           // R5 status
        '{1'b0, 1'b1, 8'h14, 1'b0, 1'b1, 8'h0C, 32'h0, 32'h0},                   // R10 invalid writes
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h80, 32'h0, 32'h8000_0029},           // R10 state kept
        '{1'b1, 1'b0, 8'h14, 1'b1, 1'b0, 8'h14, 32'h0, 32'h0},                   // R3 both read held
        '{1'b1, 1'b1, 8'h14, 1'b1, 1'b0, 8'h80, 32'h0, 32'h8000_0029}            // R4 release lock5, R5 prior state
    };

    string tags [NV] = '{"R2", "R3", "R5", "R6", "R6", "R7", "R7", "R8",
                         "R8", "R4", "R8", "R5", "R10", "R10", "R3", "R4"};

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v0, input logic w0, input logic [7:0] a0,
                         input logic v1, input logic w1, input logic [7:0] a1);
        req_valid = {v1, v0};
        req_write = {w1, w0};
        req_addr  = {a1, a0};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset clears read data
        check(rsp_rdata[31:0], 32'h0, "R9");
        check(rsp_rdata[63:32], 32'h0, "R9");
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 8'h00);
        @(posedge clk); @(negedge clk);
        check(rsp_rdata[31:0], 32'h0, "R9");  // all locks free after reset

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].v0, VECS[k].w0, VECS[k].a0, VECS[k].v1, VECS[k].w1, VECS[k].a1);
            @(posedge clk); @(negedge clk);
            check(rsp_rdata[31:0], VECS[k].e0, tags[k]);
            check(rsp_rdata[63:32], VECS[k].e1, tags[k]);
        end

        // R9: mid-run reset frees held locks
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rsp_rdata[31:0], 32'h0, "R9");
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 8'h80, 1'b1, 1'b0, 8'h7C);
        @(posedge clk); @(negedge clk);
        check(rsp_rdata[31:0], 32'h0, "R9");
        check(rsp_rdata[63:32], 32'h8000_0000, "R9");
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        @(posedge clk); @(negedge clk);
        finish_run();
    end
endmodule